// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block holds two timer lanes. Each lane has a 6-bit prescaler that feeds an 8-bit down counter. Lane 0 advances on every clock. Lane 1 advances on one of several sources:
- a fixed divide-by-four of the clock;
- the rising edges of an external pin;
- the divide-by-four ticks while the pin is high (gate);
- the divide-by-four ticks after a pin edge has started it (trigger);
- the end-of-count events of lane 0 (cascade).

When both the prescaler and the counter of a lane finish in the same step, the lane raises a one-cycle interrupt pulse. At that point the counter either parks at zero or reloads its initial value and keeps going, depending on the mode.

Software writes the initial values and drives the control levels and pulses. It can read each lane's current count at any time. The timer output pin toggles on every end of count of the lane that is selected for it. A write to an initial value only changes what the next reload uses.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset both counts read 0, both interrupt pulses are low and the timer output is low.
- R2: A prescaler initial code N in 1..63 gives one counter step every N source ticks, and code 0 gives one step every 64 ticks.
- R3: A counter initial value V in 1..255 gives V steps from load to end of count, and V = 0 gives 256 steps. Each prescaler end lowers the visible count by one.
- R4: An interrupt pulse of one cycle appears only on a source tick where the prescaler is at its last tick and the count reads 1.
- R5: With the continuous bit low (single pass), the count goes to 0 at end of count and stays there with no further interrupt until the next load pulse.
- R6: With the continuous bit high, the count reloads its initial value at end of count and keeps counting.
- R7: A low enable freezes the count and the prescaler, and a high enable resumes from the frozen values. A load pulse restarts both from their initial values and wins over a tick in the same cycle.
- R8: Writing a new initial value while a lane runs does not change its count until the next reload.
- R9: With the external-use bit low and cascade off, lane 1 ticks every fourth clock from a free-running divider cleared by reset, which ticks when it holds 3.
- R10: In external mode code 00 (clock), each rising edge of the input, after two synchroniser flops, gives lane 1 one tick.
- R11: In external mode code 01 (gate), lane 1 takes the divide-by-four ticks only while the synchronised input is high.
- R12: In external mode codes 10 (one-shot trigger) and 11 (retriggerable), lane 1 holds until a synchronised rising edge reloads it and starts divide-by-four counting. Code 10 ignores edges while a triggered count is active, and code 11 reloads on every edge. A single-pass end makes the lane wait for a new edge.
- R13: With the cascade bit high, lane 1 ticks once for each end of count of lane 0.
- R14: The timer output toggles on each end of count of the lane picked by the select bit (0 picks lane 0, 1 picks lane 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| t0PreWr | input | 1 | Write preData into lane 0 prescaler initial value |
| t1PreWr | input | 1 | Write preData into lane 1 prescaler initial value |
| t0CntWr | input | 1 | Write cntData into lane 0 counter initial value |
| t1CntWr | input | 1 | Write cntData into lane 1 counter initial value |
| preData | input | 6 | Prescaler initial code (0 means 64) |
| cntData | input | 8 | Counter initial value (0 means 256) |
| t0Load | input | 1 | Restart lane 0 from its initial values |
| t1Load | input | 1 | Restart lane 1 from its initial values |
| t0En | input | 1 | Lane 0 run enable |
| t1En | input | 1 | Lane 1 run enable |
| t0Cont | input | 1 | Lane 0 continuous (1) or single pass (0) |
| t1Cont | input | 1 | Lane 1 continuous (1) or single pass (0) |
| t1Cascade | input | 1 | Lane 1 ticks on lane 0 end of count |
| t1UseExt | input | 1 | Lane 1 uses the external input per t1ExtMode |
| t1ExtMode | input | 2 | 00 clock, 01 gate, 10 one-shot trigger, 11 retrigger |
| toutSel | input | 1 | Lane whose end of count toggles tout |
| extIn | input | 1 | Asynchronous external timer input |
| t0Count | output | 8 | Lane 0 current count |
| t1Count | output | 8 | Lane 1 current count |
| tout | output | 1 | Toggling timer output |
| irq0 | output | 1 | Lane 0 end-of-count pulse |
| irq1 | output | 1 | Lane 1 end-of-count pulse |

## Verification
Lane 0 is run with small prescaler and counter values, with the wrap codes (prescaler 0, counter 0) and with prescaler 1. These separate a divide-by-N error from an off-by-one in the terminal detection or in the zero-means-maximum encoding. Single-pass and continuous runs, enable toggling and mid-run initial writes show whether reload, park and hold are kept apart. Lane 1 is driven through each source choice with an input that toggles irregularly. Edges are sent both while a triggered count is active and after it, so the one-shot and retriggerable codes can be told apart. A cascaded run links the end events of the two lanes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic load;
    logic tick;
  } laneStrobe_t;

  typedef enum logic [1:0] {
    EXT_CLOCK  = 2'b00,
    EXT_GATE   = 2'b01,
    EXT_ONCE   = 2'b10,
    EXT_RETRIG = 2'b11
  } extMode_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  loadReq,
  input  logic [LANES-1:0]  enable,
  input  logic [LANES-1:0]  contMode,
  input  logic              t1Cascade,
  input  logic              t1UseExt,
  input  logic [1:0]        t1ExtMode,
  input  logic              extIn,
  input  logic [LANES-1:0]  eoc,
  output laneStrobe_t [LANES-1:0] strobe
);
  localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

  logic [DIV_W-1:0]     divCnt;
  logic                 divTick;
  logic [SYNC_STAGES:0] syncPipe;
  logic                 extLevel, extRise;
  logic [LANES-1:0]     done;
  logic                 triggered;
  logic                 trigMode, trigAccept, t1Base;
  logic [LANES-1:0]     laneLoad;
  extMode_e             mode;

  assign mode     = extMode_e'(t1ExtMode);
  assign divTick  = (divCnt == DIV_LAST);
  assign extLevel = syncPipe[SYNC_STAGES-1];
  assign extRise  = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      syncPipe <= '0;
    end else begin
      divCnt   <= divTick ? '0 : divCnt + 1'b1;
      syncPipe <= {syncPipe[SYNC_STAGES-1:0], extIn};
    end
  end

  assign trigMode   = t1UseExt && mode[1];
  assign trigAccept = trigMode && enable[1] && extRise &&
                      ((mode == EXT_RETRIG) || !triggered);
  assign laneLoad   = {loadReq[1] | trigAccept, loadReq[0]};

  always_comb begin
    if (t1Cascade)     t1Base = eoc[0];
    else if (!t1UseExt) t1Base = divTick;
    else begin
      case (mode)
        EXT_CLOCK: t1Base = extRise;
        EXT_GATE:  t1Base = divTick & extLevel;
        default:   t1Base = divTick;
      endcase
    end
  end

  assign strobe[0].load = laneLoad[0];
  assign strobe[0].tick = enable[0] && !done[0] && !laneLoad[0];
  assign strobe[1].load = laneLoad[1];
  assign strobe[1].tick = enable[1] && !done[1] && (!trigMode || triggered) &&
                          t1Base && !laneLoad[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= '0;
      triggered <= 1'b0;
    end else begin
      for (int g = 0; g < LANES; g++) begin
        if (laneLoad[g])                done[g] <= 1'b0;
        else if (eoc[g] && !contMode[g]) done[g] <= 1'b1;
      end
      if (loadReq[1])                  triggered <= 1'b0;
      else if (trigAccept)             triggered <= 1'b1;
      else if (eoc[1] && !contMode[1]) triggered <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LANES-1:0]            preWr,
  input  logic [LANES-1:0]            cntWr,
  input  logic [PRE_W-1:0]            preData,
  input  logic [CNT_W-1:0]            cntData,
  input  laneStrobe_t [LANES-1:0]     strobe,
  input  logic [LANES-1:0]            contMode,
  input  logic                        toutSel,
  output logic [LANES-1:0][CNT_W-1:0] count,
  output logic [LANES-1:0]            eoc,
  output logic [LANES-1:0]            irq,
  output logic                        tout
);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PRE_W-1:0] preInit, preCnt;
    logic [CNT_W-1:0] cntInit, cntVal;
    logic             preEnd;

    assign preEnd   = strobe[g].tick && (preCnt == PRE_ONE);
    assign eoc[g]   = preEnd && (cntVal == CNT_ONE);
    assign count[g] = cntVal;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        preInit <= '0;
        cntInit <= '0;
      end else begin
        if (preWr[g]) preInit <= preData;
        if (cntWr[g]) cntInit <= cntData;
      end
    end

    // zero codes wrap naturally to the maximum division / count
    always_ff @(posedge clk) begin
      if (!rstN) begin
        preCnt <= '0;
        cntVal <= '0;
      end else if (strobe[g].load) begin
        preCnt <= preInit;
        cntVal <= cntInit;
      end else if (strobe[g].tick) begin
        preCnt <= preEnd ? preInit : preCnt - 1'b1;
        if (preEnd) begin
          if (cntVal == CNT_ONE) cntVal <= contMode[g] ? cntInit : '0;
          else                   cntVal <= cntVal - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq  <= '0;
      tout <= 1'b0;
    end else begin
      irq <= eoc;
      if (eoc[toutSel]) tout <= ~tout;
    end
  end
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int CNT_W       = 8,
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             t0PreWr,
  input  logic             t1PreWr,
  input  logic             t0CntWr,
  input  logic             t1CntWr,
  input  logic [PRE_W-1:0] preData,
  input  logic [CNT_W-1:0] cntData,
  input  logic             t0Load,
  input  logic             t1Load,
  input  logic             t0En,
  input  logic             t1En,
  input  logic             t0Cont,
  input  logic             t1Cont,
  input  logic             t1Cascade,
  input  logic             t1UseExt,
  input  logic [1:0]       t1ExtMode,
  input  logic             toutSel,
  input  logic             extIn,
  output logic [CNT_W-1:0] t0Count,
  output logic [CNT_W-1:0] t1Count,
  output logic             tout,
  output logic             irq0,
  output logic             irq1
);
  laneStrobe_t [LANES-1:0]     strobe;
  logic [LANES-1:0]            eoc, irq, contMode;
  logic [LANES-1:0][CNT_W-1:0] count;

  assign contMode = {t1Cont, t0Cont};

  tmr_ctrl #(.INT_DIV(INT_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .loadReq({t1Load, t0Load}), .enable({t1En, t0En}), .contMode(contMode),
    .t1Cascade(t1Cascade), .t1UseExt(t1UseExt), .t1ExtMode(t1ExtMode),
    .extIn(extIn), .eoc(eoc), .strobe(strobe)
  );

  tmr_datapath #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .preWr({t1PreWr, t0PreWr}), .cntWr({t1CntWr, t0CntWr}),
    .preData(preData), .cntData(cntData), .strobe(strobe),
    .contMode(contMode), .toutSel(toutSel),
    .count(count), .eoc(eoc), .irq(irq), .tout(tout)
  );

  assign t0Count = count[0];
  assign t1Count = count[1];
  assign irq0    = irq[0];
  assign irq1    = irq[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             t0Load,
  input logic             t0En,
  input logic             t1Cont,
  input logic [CNT_W-1:0] t0Count,
  input logic [CNT_W-1:0] t1Count,
  input logic             tout,
  input logic             irq0,
  input logic             irq1
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // end-of-count pulse only after the count stood at one
  assert_irq_after_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    irq0 |-> ($past(t0Count) == ONE));

  // single pass parks at zero
  assert_single_parks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irq1 && !$past(t1Cont)) |-> (t1Count == '0));

  // disabled and not loaded: count frozen
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(t0En) && !$past(t0Load)) |-> (t0Count == $past(t0Count)));

  // a count change without load or wrap is a step of one
  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((t0Count != $past(t0Count)) && !$past(t0Load) && !irq0)
      |-> (t0Count == ($past(t0Count) - ONE)));

  // output only toggles with an end of count
  assert_tout_on_end_R14: assert property (@(posedge clk) disable iff (!rstN)
    (tout != $past(tout)) |-> (irq0 || irq1));
endmodule

bind tmr_pair_top tmr_pair_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_tmr_pair_top.sv
`timescale 1ns/1ps
module test_tmr_pair_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic t0PreWr = 0, t1PreWr = 0, t0CntWr = 0, t1CntWr = 0;
  logic [5:0] preData = 0;
  logic [7:0] cntData = 0;
  logic t0Load = 0, t1Load = 0, t0En = 0, t1En = 0, t0Cont = 0, t1Cont = 0;
  logic t1Cascade = 0, t1UseExt = 0, toutSel = 0, extIn = 0;
  logic [1:0] t1ExtMode = 0;
  logic [7:0] t0Count, t1Count;
  logic tout, irq0, irq1;

  always #2.5 clk = ~clk;

  tmr_pair_top i_tmr_pair_top (.*);

  int nCmp = 0, nBad = 0;
  string curReq = "R1";
  bit started = 0, finished = 0;

  // reference model state (prescaler left 1..64, counter left 0..256)
  int mPreInit[2], mCntInit[2], mPre[2], mCnt[2];
  bit mDone[2], mIrq[2];
  bit mTrig, mTout, ms1, ms2, ms3;
  int mDiv;
  bit rise, lvl, divTick, trigMode, acc, base, ld0, ld1, tk0, tk1, e0, e1;

  function automatic int preReload(int i);
    return (mPreInit[i] == 0) ? 64 : mPreInit[i];
  endfunction
  function automatic int cntReload(int i);
    return (mCntInit[i] == 0) ? 256 : mCntInit[i];
  endfunction

  task automatic laneStep(int i, bit ld, bit tk, bit cont);
    if (ld) begin
      mPre[i] = preReload(i);
      mCnt[i] = cntReload(i);
    end else if (tk) begin
      if (mPre[i] == 1) begin
        mPre[i] = preReload(i);
        if (mCnt[i] == 1) mCnt[i] = cont ? cntReload(i) : 0;
        else mCnt[i] = (mCnt[i] == 0) ? 255 : mCnt[i] - 1;
      end else mPre[i] = mPre[i] - 1;
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mPreInit[i] = 0; mCntInit[i] = 0; mPre[i] = 64; mCnt[i] = 256;
        mDone[i] = 0; mIrq[i] = 0;
      end
      mTrig = 0; mTout = 0; ms1 = 0; ms2 = 0; ms3 = 0; mDiv = 0;
    end else begin
      rise = ms2 && !ms3;
      lvl = ms2;
      divTick = (mDiv == 3);
      ld0 = t0Load;
      tk0 = t0En && !mDone[0] && !ld0;
      e0 = tk0 && mPre[0] == 1 && mCnt[0] == 1;
      trigMode = t1UseExt && t1ExtMode[1];
      acc = trigMode && t1En && rise && (t1ExtMode == 2'd3 || !mTrig);
      ld1 = t1Load || acc;
      if (t1Cascade) base = e0;
      else if (!t1UseExt) base = divTick;
      else if (t1ExtMode == 2'd0) base = rise;
      else if (t1ExtMode == 2'd1) base = divTick && lvl;
      else base = divTick;
      tk1 = t1En && !mDone[1] && (!trigMode || mTrig) && base && !ld1;
      e1 = tk1 && mPre[1] == 1 && mCnt[1] == 1;
      laneStep(0, ld0, tk0, t0Cont);
      laneStep(1, ld1, tk1, t1Cont);
      if (ld0) mDone[0] = 0; else if (e0 && !t0Cont) mDone[0] = 1;
      if (ld1) mDone[1] = 0; else if (e1 && !t1Cont) mDone[1] = 1;
      if (t1Load) mTrig = 0; else if (acc) mTrig = 1; else if (e1 && !t1Cont) mTrig = 0;
      mIrq[0] = e0; mIrq[1] = e1;
      if (toutSel ? e1 : e0) mTout = !mTout;
      if (t0PreWr) mPreInit[0] = preData;
      if (t1PreWr) mPreInit[1] = preData;
      if (t0CntWr) mCntInit[0] = cntData;
      if (t1CntWr) mCntInit[1] = cntData;
      ms3 = ms2; ms2 = ms1; ms1 = extIn;
      mDiv = (mDiv + 1) % 4;
    end
  end

  task automatic check(string what, int act, int exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check("t0Count", t0Count, mCnt[0] % 256);
      check("t1Count", t1Count, mCnt[1] % 256);
      check("irq0", irq0, mIrq[0]);
      check("irq1", irq1, mIrq[1]);
      check("tout", tout, mTout);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeInit(int lane, int pre, int cnt);
    @(negedge clk);
    preData = 6'(pre); cntData = 8'(cnt);
    if (lane == 0) begin t0PreWr = 1; t0CntWr = 1; end
    else begin t1PreWr = 1; t1CntWr = 1; end
    @(negedge clk);
    t0PreWr = 0; t0CntWr = 0; t1PreWr = 0; t1CntWr = 0;
  endtask

  task automatic pulseLoad(int lane);
    @(negedge clk);
    if (lane == 0) t0Load = 1; else t1Load = 1;
    @(negedge clk);
    t0Load = 0; t1Load = 0;
  endtask

  task automatic extPulse(int high, int low);
    extIn = 1; wait_n(high);
    extIn = 0; wait_n(low);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    wait_n(4);
    rstN = 1;
    wait_n(3);

    // R2 R3 R4 R6: lane 0 continuous, small values
    curReq = "R2 R3 R4 R6 small";
    writeInit(0, 3, 5);
    t0Cont = 1; t0En = 1;
    pulseLoad(0);
    wait_n(60);
    // R2 R3: zero codes mean 64 and 256
    curReq = "R2 R3 wrap codes";
    writeInit(0, 0, 2);
    pulseLoad(0);
    wait_n(300);
    writeInit(0, 1, 0);
    pulseLoad(0);
    wait_n(600);

    // R5: single pass parks at zero
    curReq = "R5 single";
    t0Cont = 0;
    writeInit(0, 2, 3);
    pulseLoad(0);
    wait_n(40);

    // R7: stop, resume, restart
    curReq = "R7 stop resume";
    t0Cont = 1;
    writeInit(0, 2, 6);
    pulseLoad(0);
    wait_n(7);
    t0En = 0; wait_n(9);
    t0En = 1; wait_n(5);
    pulseLoad(0);
    wait_n(10);

    // R8: initial write mid-run affects only next reload
    curReq = "R8 mid write";
    writeInit(0, 1, 9);
    wait_n(30);

    // R9: lane 1 on divide-by-four
    curReq = "R9 div4";
    t0En = 0;
    toutSel = 1;
    t1Cont = 1; t1En = 1;
    writeInit(1, 2, 3);
    pulseLoad(1);
    wait_n(80);

    // R10: external clock
    curReq = "R10 ext clock";
    t1UseExt = 1; t1ExtMode = 2'd0;
    writeInit(1, 1, 4);
    pulseLoad(1);
    for (int k = 0; k < 14; k++) extPulse(1 + (k % 3), 2 + (k % 2));
    wait_n(5);

    // R11: gate
    curReq = "R11 gate";
    t1ExtMode = 2'd1;
    pulseLoad(1);
    extIn = 1; wait_n(23);
    extIn = 0; wait_n(17);
    extIn = 1; wait_n(30);
    extIn = 0; wait_n(6);

    // R12: one-shot trigger
    curReq = "R12 one-shot";
    t1ExtMode = 2'd2; t1Cont = 0;
    writeInit(1, 2, 4);
    pulseLoad(1);
    wait_n(12);
    extPulse(2, 10);
    extPulse(2, 30);
    wait_n(20);
    extPulse(3, 45);

    // R12: retriggerable
    curReq = "R12 retrigger";
    t1ExtMode = 2'd3;
    pulseLoad(1);
    extPulse(2, 8);
    extPulse(2, 8);
    extPulse(2, 50);

    // R13 R14: cascade, output on lane 1 then lane 0
    curReq = "R13 R14 cascade";
    t1UseExt = 0; t1Cascade = 1; t1Cont = 1; t0Cont = 1;
    writeInit(0, 1, 2);
    writeInit(1, 1, 3);
    t0En = 1;
    pulseLoad(0);
    pulseLoad(1);
    wait_n(40);
    toutSel = 0;
    wait_n(20);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule